// File: doc/BRIEF.md
# Protected Register Unlock Sequencer

This block keeps a group of write-protected configuration fields safe from stray software writes. Software opens them by writing a fixed three-word key to one lock-control address on a simple register bus. The words must arrive in one order, and any wrong value sends the matcher back to its first step. Once the key completes, the block enters an unlocked state and asserts a write-enable qualifier. Other register blocks AND that qualifier into the write strobes of their protected fields. A write of zero to the lock-control address closes the block again.

Software reads the lock-control address to learn the state, so it can poll after the last key word until the unlock shows. A small demonstration register sits at a second address and shows the gating. Its two clock-source select fields are protected. Its upper byte is always writable.

Top module: `prot_unlock_seq`

## Requirements
- R1: After reset the block is locked, `prot_wr_ok` is 0, the key matcher is at its first step and `cfg_q` holds 16'h0007.
- R2: Writing 32'h59, then 32'h16, then 32'h88 to address 12'h100 unlocks the block. `prot_wr_ok` rises in the cycle after the clock edge that takes the third write.
- R3: While locked, a write to 12'h100 of a value that is not the next key word sends the matcher back to its first step. If that value is 32'h59, the matcher goes to the second step instead, as a fresh first word.
- R4: Bus cycles to any other address, reads, and idle cycles between key words leave the matcher's progress unchanged.
- R5: Writing 32'h0 to 12'h100 locks the block and clears the matcher, whatever state it was in.
- R6: While unlocked, a nonzero write to 12'h100 leaves the block unlocked.
- R7: The demo register sits at 12'h200. Bits [2:0] (core clock source) and [5:3] (tick clock source) are protected. A write to them while locked is dropped and they keep their value. Bits [15:8] take every write.
- R8: Reading 12'h100 returns 1 when unlocked and 0 when locked. Reading 12'h200 returns `cfg_q` zero-extended. Any other address, or no read, returns 0. `rdata` is combinational from the read inputs.
- R9: A read never changes the lock state, the matcher or `cfg_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en` |
| prot_wr_ok | output | 1 | High while unlocked, qualifies protected writes |
| cfg_q | output | 16 | Demo register contents |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that every bus input is stable between clock edges. The stimulus drives every access on the falling edge and holds it for one full cycle. It issues reads and writes from separate tasks, so the two strobes never overlap. Key sequences are interleaved with foreign writes, reads, zero writes and repeated first words. This exercises every restart path of the matcher within those assumptions.

// File: rtl/prot_unlock_seq.sv
module prot_unlock_seq #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CFG_W = 16,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'h100,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h200,
  parameter logic [DATA_W-1:0] KEY_A = 32'h59,
  parameter logic [DATA_W-1:0] KEY_B = 32'h16,
  parameter logic [DATA_W-1:0] KEY_C = 32'h88,
  parameter logic [CFG_W-1:0] CFG_RST = 16'h0007,
  parameter logic [CFG_W-1:0] PROT_MASK = 16'h003F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              prot_wr_ok,
  output logic [CFG_W-1:0]  cfg_q
);
  typedef enum logic [1:0] {WAIT_A, WAIT_B, WAIT_C} step_t;

  step_t step;
  logic  unl;

  wire lock_wr = wr_en && (addr == LOCK_ADDR);
  wire cfg_wr  = wr_en && (addr == CFG_ADDR);
  wire is_zero = (wdata == '0);
  wire hit_a   = (wdata == KEY_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= WAIT_A;
      unl  <= 1'b0;
    end else if (lock_wr) begin
      if (is_zero) begin
        unl  <= 1'b0;
        step <= WAIT_A;
      end else if (!unl) begin
        case (step)
          WAIT_A: step <= hit_a ? WAIT_B : WAIT_A;
          WAIT_B: step <= (wdata == KEY_B) ? WAIT_C : (hit_a ? WAIT_B : WAIT_A);
          WAIT_C: begin
            if (wdata == KEY_C) begin
              unl  <= 1'b1;
              step <= WAIT_A;
            end else begin
              step <= hit_a ? WAIT_B : WAIT_A;
            end
          end
          default: step <= WAIT_A;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= CFG_RST;
    else if (cfg_wr)
      cfg_q <= unl ? wdata[CFG_W-1:0]
                   : (cfg_q & PROT_MASK) | (wdata[CFG_W-1:0] & ~PROT_MASK);
  end

  assign prot_wr_ok = unl;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == LOCK_ADDR)     rdata[0] = unl;
      else if (addr == CFG_ADDR) rdata[CFG_W-1:0] = cfg_q;
    end
  end
endmodule

module prot_unlock_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CFG_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              prot_wr_ok,
  input logic [CFG_W-1:0]  cfg_q
);
  a_r2_rise_needs_last_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_wr_ok) |-> $past(wr_en && addr == 12'h100 && wdata == 32'h88));

  a_r4_other_traffic_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 12'h100) |=> $stable(prot_wr_ok));

  a_r5_zero_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h100 && wdata == '0) |=> !prot_wr_ok);

  a_r6_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr_ok && wr_en && addr == 12'h100 && wdata != '0) |=> prot_wr_ok);

  a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_wr_ok && wr_en && addr == 12'h200) |=> cfg_q[5:0] == $past(cfg_q[5:0]));

  a_r8_lock_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 12'h100) |-> rdata == {{(DATA_W-1){1'b0}}, prot_wr_ok});

  a_r9_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> $stable(cfg_q) && $stable(prot_wr_ok));
endmodule

bind prot_unlock_seq prot_unlock_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .prot_wr_ok(prot_wr_ok), .cfg_q(cfg_q)
);

// File: tb/prot_unlock_seq_test.sv
`timescale 1ns/1ps
module prot_unlock_seq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        prot_wr_ok;
  logic [15:0] cfg_q;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  int          m_step;
  bit          m_unl;
  logic [15:0] m_cfg;

  always #5 clk = ~clk;

  prot_unlock_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .prot_wr_ok(prot_wr_ok), .cfg_q(cfg_q)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_unl = 0; m_cfg = 16'h0007;
    end else if (wr_en && addr == 12'h100) begin
      if (wdata == 0) begin m_unl = 0; m_step = 0; end
      else if (!m_unl) begin
        if (m_step == 0 && wdata == 32'h59) m_step = 1;
        else if (m_step == 1 && wdata == 32'h16) m_step = 2;
        else if (m_step == 2 && wdata == 32'h88) begin m_unl = 1; m_step = 0; end
        else if (wdata == 32'h59) m_step = 1;
        else m_step = 0;
      end
    end else if (wr_en && addr == 12'h200) begin
      if (m_unl) m_cfg = wdata[15:0];
      else m_cfg = {wdata[15:8], m_cfg[7:6] & wdata[7:6] | m_cfg[7:6] & 2'b00 | wdata[7:6], m_cfg[5:0]};
    end
  end

  function automatic logic [31:0] exp_rd();
    if (!rd_en) return 0;
    if (addr == 12'h100) return {31'b0, m_unl};
    if (addr == 12'h200) return {16'b0, m_cfg};
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #4;
    if (!done) begin
      chk(cur_req, {31'b0, prot_wr_ok}, {31'b0, m_unl}, "prot_wr_ok");
      chk(cur_req, {16'b0, cfg_q}, {16'b0, m_cfg}, "cfg_q");
      chk(cur_req, rdata, exp_rd(), "rdata");
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; rd_en = 0; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk); rd_en = 1; wr_en = 0; addr = a;
    #2 chk(req, rdata, exp, "read");
    @(negedge clk); rd_en = 0; addr = '0;
  endtask

  task automatic key3();
    wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 32'h88);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    rd(12'h100, 0, "R1");
    rd(12'h200, 32'h0007, "R1");

    cur_req = "R2";
    key3();
    rd(12'h100, 1, "R2");

    cur_req = "R5";
    wr(12'h100, 0);
    rd(12'h100, 0, "R5");
    wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 0); wr(12'h100, 32'h88);
    rd(12'h100, 0, "R5");

    cur_req = "R3";
    wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 32'h77); wr(12'h100, 32'h88);
    rd(12'h100, 0, "R3");
    wr(12'h100, 32'h16); wr(12'h100, 32'h88);
    rd(12'h100, 0, "R3");
    wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 32'h59);
    wr(12'h100, 32'h16); wr(12'h100, 32'h88);
    rd(12'h100, 1, "R3");
    wr(12'h100, 0);
    wr(12'h100, 32'h59); wr(12'h100, 32'h59); wr(12'h100, 32'h16); wr(12'h100, 32'h88);
    rd(12'h100, 1, "R3");
    wr(12'h100, 0);
    wr(12'h100, 32'h159); wr(12'h100, 32'h16); wr(12'h100, 32'h88);
    rd(12'h100, 0, "R3");

    cur_req = "R7";
    wr(12'h200, 32'hA53A);
    rd(12'h200, 32'hA507, "R7");

    cur_req = "R4";
    wr(12'h100, 32'h59);
    wr(12'h300, 32'h1234);
    rd(12'h100, 0, "R4");
    repeat (3) @(negedge clk);
    wr(12'h100, 32'h16);
    wr(12'h200, 32'h0000);
    wr(12'h100, 32'h88);
    rd(12'h100, 1, "R4");

    cur_req = "R6";
    wr(12'h100, 32'h88); wr(12'h100, 32'h12345); wr(12'h100, 32'h59);
    rd(12'h100, 1, "R6");

    cur_req = "R7";
    wr(12'h200, 32'h0F1B);
    rd(12'h200, 32'h0F1B, "R7");
    wr(12'h100, 0);
    wr(12'h200, 32'hFF24);
    rd(12'h200, 32'hFF1B, "R7");

    cur_req = "R8";
    rd(12'h300, 0, "R8");
    rd(12'h104, 0, "R8");
    rd(12'h200, 32'hFF1B, "R8");

    cur_req = "R9";
    wr(12'h100, 32'h59);
    rd(12'h100, 0, "R9");
    rd(12'h200, 32'hFF1B, "R9");
    wr(12'h100, 32'h16);
    rd(12'h100, 0, "R9");
    wr(12'h100, 32'h88);
    rd(12'h100, 1, "R9");
    chk("R9", {16'b0, cfg_q}, 32'hFF1B, "cfg after reads");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule